// File: doc/BRIEF.md
# Instruction Fetch Unit with Decoupling Queue

This block is the front end of a simple in-order pipeline. It keeps a byte-addressed program counter that starts at zero and advances by one instruction word on every fetch through its own incrementer. It reads 32-bit instruction words from a separate instruction memory with a fixed access latency, keeping one request in flight at a time. Each returned word is written, together with its address, into a bounded first-in first-out queue. The decode stage drains that queue through a valid/ready handshake.

Fetch halts when the queue has no free slot. It also halts as soon as a conditional branch enters the queue, because there is no prediction. While it waits, the unit holds the branch target, computed from the branch's own address and its signed word offset. When the execute stage sends a one-cycle resolve pulse, a taken outcome loads the target into the program counter. A not-taken outcome resumes at the address already incremented past the branch. The current occupancy is exposed so that buffer utilisation can be measured.

Top module: `fetch_queue_unit`

## Requirements
- R1: While reset is held and in the first cycle after its release, `qCount` is 0 and `deqValid` is 0. The first request issued after reset carries address 0.
- R2: At most one memory request is outstanding. A response is expected exactly `MEM_LAT` cycles after its request. With the queue not full and no branch pending, consecutive requests are `MEM_LAT`+1 cycles apart.
- R3: A word whose bits [31:26] equal 6'b000100 is a conditional branch. Once such a word has been written into the queue, no request is issued until a resolve pulse arrives.
- R4: No request is issued while `qCount` equals `QUEUE_DEPTH`, so the queue never overflows. Fetch resumes once decode frees a slot.
- R5: Decode receives entries in fetch order on `deqInstr` and `deqPc`. `deqValid` is 1 exactly when the queue is non-empty, and an entry is removed only in a cycle with `deqValid` and `deqReady` both 1.
- R6: On a resolve pulse with `resolveTaken`=1, the next request address is the branch address + 4 + 4 × sign-extended bits [15:0] of the branch word.
- R7: Sequential requests step the address by 4. On a resolve pulse with `resolveTaken`=0, the next request address is the branch address + 4.
- R8: A resolve pulse arriving while no branch is pending has no effect on the request address stream.
- R9: `qCount` equals the number of responses written minus the number of entries removed since reset. A write and a removal in the same cycle leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| imReqValid | output | 1 | Instruction memory read request |
| imReqAddr | output | ADDR_W | Byte address of the request |
| imRspValid | input | 1 | Response valid, `MEM_LAT` cycles after the request |
| imRspData | input | DATA_W | Returned instruction word |
| deqValid | output | 1 | Queue head holds an instruction |
| deqReady | input | 1 | Decode takes the head this cycle |
| deqInstr | output | DATA_W | Instruction word at the queue head |
| deqPc | output | ADDR_W | Address of the instruction at the queue head |
| resolveValid | input | 1 | One-cycle branch resolution pulse |
| resolveTaken | input | 1 | Branch outcome, valid with `resolveValid` |
| qCount | output | CNT_W | Number of occupied queue entries |

## Verification
A wrong program counter or a stale target shows at the memory port on the very next request after a resolve pulse, as an address that differs from branch + 4 or the computed target. A lost branch-pending flag shows within `MEM_LAT`+1 cycles as a request issued past an unresolved branch. Corrupted read or write pointers show at decode as out-of-order `deqPc` values or instructions that do not match their address. A drifting occupancy count shows either as a request while the queue is full or as `qCount` disagreeing with the number of responses minus the number of dequeues.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_WAIT   = 2'd1,
    ST_BRANCH = 2'd2
  } fetch_state_e;

  // Strobes from control to datapath, one per datapath action.
  typedef struct packed {
    logic issue;       // start a memory read at pc, step pc
    logic enqueue;     // write the response into the queue
    logic dequeue;     // remove the queue head
    logic holdTarget;  // capture the branch target of the response
    logic redirect;    // load the held target into pc
  } fetch_strobe_t;

  localparam int          OPCODE_W      = 6;
  localparam int          IMM_W         = 16;
  localparam logic [5:0]  BRANCH_OPCODE = 6'b000100;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          qFull,
  input  logic          qEmpty,
  input  logic          rspValid,
  input  logic          rspIsBranch,
  input  logic          deqReady,
  input  logic          resolveValid,
  input  logic          resolveTaken,
  output fetch_strobe_t strobes
);

  fetch_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    case (state)
      ST_FETCH: begin
        if (!qFull) begin
          strobes.issue = 1'b1;
          nextState     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rspValid) begin
          strobes.enqueue = 1'b1;
          if (rspIsBranch) begin
            strobes.holdTarget = 1'b1;
            nextState          = ST_BRANCH;
          end else begin
            nextState = ST_FETCH;
          end
        end
      end
      ST_BRANCH: begin
        if (resolveValid) begin
          strobes.redirect = resolveTaken;
          nextState        = ST_FETCH;
        end
      end
      default: nextState = ST_FETCH;
    endcase
    strobes.dequeue = deqReady && !qEmpty;
  end

endmodule

// File: rtl/fetch_dpath.sv
module fetch_dpath
  import fetch_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int QUEUE_DEPTH = 4,
  localparam int PTR_W      = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1,
  localparam int CNT_W      = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetch_strobe_t     strobes,
  input  logic [DATA_W-1:0] rspData,
  output logic              rspIsBranch,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              qFull,
  output logic              qEmpty,
  output logic [DATA_W-1:0] headInstr,
  output logic [ADDR_W-1:0] headPc,
  output logic [CNT_W-1:0]  count
);

  localparam int          INSTR_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(INSTR_BYTES);

  // ---------------- program counter and branch target ----------------
  logic [ADDR_W-1:0] pc, pcNext, reqPc, targetReg, branchOffset;
  logic [IMM_W-1:0]  imm;

  assign pcNext       = pc + PC_STEP;           // dedicated incrementer
  assign imm          = rspData[IMM_W-1:0];
  assign branchOffset = {{(ADDR_W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
  assign rspIsBranch  = (rspData[DATA_W-1 -: OPCODE_W] == BRANCH_OPCODE);
  assign reqAddr      = pc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc        <= '0;
      reqPc     <= '0;
      targetReg <= '0;
    end else begin
      if (strobes.redirect)   pc <= targetReg;
      else if (strobes.issue) pc <= pcNext;
      if (strobes.issue)      reqPc <= pc;
      if (strobes.holdTarget) targetReg <= reqPc + PC_STEP + branchOffset;
    end
  end

  // ---------------- instruction queue ----------------
  logic [DATA_W-1:0] instrMem [QUEUE_DEPTH];
  logic [ADDR_W-1:0] pcMem    [QUEUE_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    for (genvar e = 0; e < QUEUE_DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
        if (strobes.enqueue && (wrPtr == PTR_W'(e))) begin
          instrMem[e] <= rspData;
          pcMem[e]    <= reqPc;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.enqueue) wrPtr <= ptrInc(wrPtr);
      if (strobes.dequeue) rdPtr <= ptrInc(rdPtr);
      case ({strobes.enqueue, strobes.dequeue})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign qFull     = (count == CNT_W'(QUEUE_DEPTH));
  assign qEmpty    = (count == '0);
  assign headInstr = instrMem[rdPtr];
  assign headPc    = pcMem[rdPtr];

endmodule

// File: rtl/fetch_queue_unit.sv
module fetch_queue_unit
  import fetch_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int QUEUE_DEPTH = 4,
  parameter int MEM_LAT     = 2,
  localparam int CNT_W      = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              imReqValid,
  output logic [ADDR_W-1:0] imReqAddr,
  input  logic              imRspValid,
  input  logic [DATA_W-1:0] imRspData,
  output logic              deqValid,
  input  logic              deqReady,
  output logic [DATA_W-1:0] deqInstr,
  output logic [ADDR_W-1:0] deqPc,
  input  logic              resolveValid,
  input  logic              resolveTaken,
  output logic [CNT_W-1:0]  qCount
);

  fetch_strobe_t strobes;
  logic qFull, qEmpty, rspIsBranch;

  fetch_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .qFull        (qFull),
    .qEmpty       (qEmpty),
    .rspValid     (imRspValid),
    .rspIsBranch  (rspIsBranch),
    .deqReady     (deqReady),
    .resolveValid (resolveValid),
    .resolveTaken (resolveTaken),
    .strobes      (strobes)
  );

  fetch_dpath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .QUEUE_DEPTH (QUEUE_DEPTH)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rspData     (imRspData),
    .rspIsBranch (rspIsBranch),
    .reqAddr     (imReqAddr),
    .qFull       (qFull),
    .qEmpty      (qEmpty),
    .headInstr   (deqInstr),
    .headPc      (deqPc),
    .count       (qCount)
  );

  assign imReqValid = strobes.issue;
  assign deqValid   = !qEmpty;

endmodule

// File: rtl/fetch_queue_checker.sv
module fetch_queue_checker
  import fetch_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int QUEUE_DEPTH = 4,
  localparam int CNT_W      = $clog2(QUEUE_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              imReqValid,
  input logic [ADDR_W-1:0] imReqAddr,
  input logic              imRspValid,
  input logic [5:0]        rspOpcode,
  input logic              deqValid,
  input logic              deqReady,
  input logic              resolveValid,
  input logic [CNT_W-1:0]  qCount
);

  logic seenReq, pendModel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenReq   <= 1'b0;
      pendModel <= 1'b0;
    end else begin
      if (imReqValid) seenReq <= 1'b1;
      if (imRspValid && rspOpcode == BRANCH_OPCODE) pendModel <= 1'b1;
      else if (resolveValid) pendModel <= 1'b0;
    end
  end

  assert_first_addr_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (imReqValid && !seenReq) |-> (imReqAddr == '0));

  assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (!rstN)
    imReqValid |=> !imReqValid);

  assert_branch_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    pendModel |-> !imReqValid);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (imReqValid || imRspValid) |-> (qCount < CNT_W'(QUEUE_DEPTH)));

  assert_pop_decrements_R5: assert property (@(posedge clk) disable iff (!rstN)
    (deqValid && deqReady && !imRspValid) |=> (qCount == $past(qCount) - 1'b1));

  assert_push_increments_R9: assert property (@(posedge clk) disable iff (!rstN)
    (imRspValid && !(deqValid && deqReady)) |=> (qCount == $past(qCount) + 1'b1));

endmodule

bind fetch_queue_unit fetch_queue_checker #(
  .ADDR_W      (ADDR_W),
  .QUEUE_DEPTH (QUEUE_DEPTH)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .imReqValid   (imReqValid),
  .imReqAddr    (imReqAddr),
  .imRspValid   (imRspValid),
  .rspOpcode    (imRspData[DATA_W-1 -: 6]),
  .deqValid     (deqValid),
  .deqReady     (deqReady),
  .resolveValid (resolveValid),
  .qCount       (qCount)
);

// File: tb/fetch_queue_unit_tb.sv
module fetch_queue_unit_tb_top;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;
  localparam int LAT    = 2;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LOG_N  = 512;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              imReqValid;
  logic [ADDR_W-1:0] imReqAddr;
  logic              imRspValid;
  logic [DATA_W-1:0] imRspData;
  logic              deqValid;
  logic              deqReady = 1'b0;
  logic [DATA_W-1:0] deqInstr;
  logic [ADDR_W-1:0] deqPc;
  logic              resolveValid = 1'b0;
  logic              resolveTaken = 1'b0;
  logic [CNT_W-1:0]  qCount;

  always #2 clk = ~clk;  // 250 MHz

  fetch_queue_unit #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .QUEUE_DEPTH(DEPTH), .MEM_LAT(LAT)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .imReqValid(imReqValid), .imReqAddr(imReqAddr),
    .imRspValid(imRspValid), .imRspData(imRspData),
    .deqValid(deqValid), .deqReady(deqReady),
    .deqInstr(deqInstr), .deqPc(deqPc),
    .resolveValid(resolveValid), .resolveTaken(resolveTaken),
    .qCount(qCount)
  );

  // ---------------- program image ----------------
  logic [31:0] brAddr = 32'hFFFF_FFF0;
  logic [15:0] brOff  = 16'd0;

  function automatic logic [31:0] progWord(input logic [31:0] a);
    if (a == brAddr) return {6'b000100, 5'd1, 5'd2, brOff};
    return {6'b101000, 10'd0, a[17:2]};
  endfunction

  // ---------------- fixed-latency memory model ----------------
  logic [LAT-1:0] pv;
  logic [31:0]    pa [LAT];

  always @(posedge clk) begin
    if (!rstN) pv <= '0;
    else begin
      pv[0] <= imReqValid;
      pa[0] <= imReqAddr;
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pa[i] <= pa[i-1];
      end
    end
  end

  always_comb begin
    imRspValid = pv[LAT-1];
    imRspData  = progWord(pa[LAT-1]);
  end

  // ---------------- port logs ----------------
  int          cyc = 0, reqN = 0, rspN = 0, deqN = 0;
  logic [31:0] reqLog [LOG_N];
  int          reqCyc [LOG_N];
  logic [31:0] deqPcLog [LOG_N];
  logic [31:0] deqInLog [LOG_N];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (imReqValid && reqN < LOG_N) begin
        reqLog[reqN] <= imReqAddr;
        reqCyc[reqN] <= cyc;
        reqN <= reqN + 1;
      end
      if (imRspValid) rspN <= rspN + 1;
      if (deqValid && deqReady && deqN < LOG_N) begin
        deqPcLog[deqN] <= deqPc;
        deqInLog[deqN] <= deqInstr;
        deqN <= deqN + 1;
      end
    end
  end

  // ---------------- checking ----------------
  int nChecks = 0, nFails = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; deqReady = 1'b0; resolveValid = 1'b0; resolveTaken = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseResolve(input bit taken);
    resolveValid = 1'b1; resolveTaken = taken;
    @(negedge clk);
    resolveValid = 1'b0; resolveTaken = 1'b0;
  endtask

  // R1: reset state and first address
  task automatic testReset();
    brAddr = 32'hFFFF_FFF0;
    doReset();
    check(qCount == 0, "R1 qCount in reset", qCount, 0);
    check(deqValid == 1'b0, "R1 deqValid in reset", deqValid, 0);
    rstN = 1'b1;
    #1;
    check(imReqValid == 1'b1, "R1 first request", imReqValid, 1);
    check(imReqAddr == 0, "R1 first address", imReqAddr, 0);
    check(qCount == 0, "R1 qCount after reset", qCount, 0);
  endtask

  // R2, R4, R7: fill the queue with decode stalled, then free one slot
  task automatic testFill();
    int base;
    brAddr = 32'hFFFF_FFF0;
    doReset();
    base = reqN;
    rstN = 1'b1;
    repeat (40) @(negedge clk);
    check(reqN - base == DEPTH, "R4 requests when full", reqN - base, DEPTH);
    check(qCount == DEPTH, "R4 qCount full", qCount, DEPTH);
    check(reqCyc[base+1] - reqCyc[base] == LAT + 1, "R2 request spacing",
          reqCyc[base+1] - reqCyc[base], LAT + 1);
    for (int i = 0; i < DEPTH; i++)
      check(reqLog[base+i] == 32'(4*i), "R7 sequential address", reqLog[base+i], 4*i);
    check(deqValid && deqPc == 0, "R5 head pc", deqPc, 0);
    check(deqInstr == progWord(0), "R5 head instr", deqInstr, progWord(0));
    deqReady = 1'b1;
    @(negedge clk);
    deqReady = 1'b0;
    repeat (20) @(negedge clk);
    check(reqN - base == DEPTH + 1, "R4 resume after slot freed", reqN - base, DEPTH + 1);
    check(reqLog[base+DEPTH] == 32'(4*DEPTH), "R4 resume address",
          reqLog[base+DEPTH], 4*DEPTH);
    check(qCount == DEPTH, "R9 count after pop and refill", qCount, DEPTH);
  endtask

  // R5, R9: continuous drain, order and occupancy bookkeeping
  task automatic testDrain();
    int rb, db;
    brAddr = 32'hFFFF_FFF0;
    doReset();
    rb = rspN; db = deqN;
    rstN = 1'b1;
    deqReady = 1'b1;
    for (int k = 0; k < 3; k++) begin
      repeat (7) @(negedge clk);
      check(qCount == CNT_W'((rspN - rb) - (deqN - db)), "R9 count bookkeeping",
            qCount, (rspN - rb) - (deqN - db));
    end
    repeat (40) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      check(deqPcLog[db+i] == 32'(4*i), "R5 dequeue order", deqPcLog[db+i], 4*i);
      check(deqInLog[db+i] == progWord(32'(4*i)), "R5 dequeue instr",
            deqInLog[db+i], progWord(32'(4*i)));
    end
    deqReady = 1'b0;
  endtask

  // R3, R6, R7: branch stall and redirect
  task automatic testBranch(input logic [31:0] ba, input int off, input bit taken);
    int base;
    longint expAddr;
    brAddr = ba; brOff = 16'(off);
    doReset();
    base = reqN;
    rstN = 1'b1;
    deqReady = 1'b1;
    repeat (50) @(negedge clk);
    check(reqN - base == int'(ba / 4) + 1, "R3 no fetch past branch",
          reqN - base, ba / 4 + 1);
    check(reqLog[reqN-1] == ba, "R3 last request is branch", reqLog[reqN-1], ba);
    pulseResolve(taken);
    repeat (10) @(negedge clk);
    expAddr = taken ? longint'(ba) + 4 + 4 * off : longint'(ba) + 4;
    if (taken)
      check(reqLog[base + ba/4 + 1] == 32'(expAddr), "R6 taken target",
            reqLog[base + ba/4 + 1], expAddr);
    else
      check(reqLog[base + ba/4 + 1] == 32'(expAddr), "R7 not-taken resume",
            reqLog[base + ba/4 + 1], expAddr);
    deqReady = 1'b0;
  endtask

  // R8: stray resolve pulses leave the address stream alone
  task automatic testIgnore();
    int base;
    brAddr = 32'hFFFF_FFF0;
    doReset();
    base = reqN;
    rstN = 1'b1;
    deqReady = 1'b1;
    repeat (4) @(negedge clk);
    pulseResolve(1'b1);
    repeat (2) @(negedge clk);
    pulseResolve(1'b1);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 8; i++)
      check(reqLog[base+i] == 32'(4*i), "R8 stray resolve ignored", reqLog[base+i], 4*i);
    deqReady = 1'b0;
  endtask

  initial begin
    testReset();
    testFill();
    testDrain();
    testBranch(32'd8, 5, 1'b0);
    testBranch(32'd20, -3, 1'b1);
    testBranch(32'd8, 5, 1'b1);
    testIgnore();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule